// File: doc/BRIEF.md
# Configuration Upload Storage Sequencer

This block turns a short instruction script, kept in a scratch-pad window of the register space, into a byte image for nonvolatile storage. It reads one script byte at a time. A data instruction makes it copy the instruction and its two address bytes to storage. It then reads the addressed run of register bytes, writes those bytes out, and closes the transfer with a checksum byte. Any other code except pause and end is copied through as a single byte and is not acted on.

The block keeps two pointers. The script pointer indexes the scratch-pad window. The storage pointer is the address of the next storage write. A pause code stops the walk and keeps both pointers where they are, so several independent scripts can be stored one after another. An end code is stored, then both pointers return to zero and the block goes idle.

Storage writes use a valid/ready stream. `st_valid` rises with `st_addr` and `st_data` present. All three stay unchanged until a cycle in which `st_ready` is high, and that cycle completes the write. The sink may hold `st_ready` low for any number of cycles, and the block simply waits. The register read port is combinational: `rd_data` must reflect `rd_addr` within the same cycle. `SP_BASE` must be aligned to the scratch-pad size of 2^`SP_AW` bytes.

Top module: `cfg_upload_seq`

## Requirements
- R1: After reset `busy` and `st_valid` are 0. A one-cycle `start` while idle makes `busy` high from the next cycle. `start` has no effect while `busy` is high.
- R2: A script byte N in 0x00..0x7F is a data instruction. The block writes N to storage, then the two address bytes, then N+1 register bytes read from addresses A, A+1, …, A+N. The address is 16 bits and wraps past 0xFFFF.
- R3: The address A is taken MSB-first. The first byte after the instruction supplies A[15:8] and the second supplies A[7:0]. Both bytes are also copied to storage in that order.
- R4: Right after the last data byte of a transfer, one more byte is written. It is the modulo-256 sum of the instruction byte, both address bytes and all data bytes of that transfer.
- R5: Every script byte in 0x80..0xFD is written to storage as exactly one byte. The next script byte is then processed as an instruction.
- R6: Pause (0xFE) writes nothing and drops `busy`. The script pointer moves just past the pause byte and the storage pointer keeps its value. The next `start` continues the walk there, with storage writes at the next unused address.
- R7: End (0xFF) is written to storage. Then both pointers become zero and `busy` drops. The next `start` reads the script from offset 0 and writes from storage address 0.
- R8: While `st_valid` is high and `st_ready` is low, `st_valid`, `st_addr` and `st_data` stay unchanged in the next cycle.
- R9: Accepted storage writes use consecutive addresses, and the storage pointer changes only in a cycle that completes a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or resume a walk (sampled when idle) |
| busy | output | 1 | High while a walk is in progress |
| rd_addr | output | 16 | Register read address (script window or data) |
| rd_data | input | 8 | Register read data for `rd_addr`, same cycle |
| st_valid | output | 1 | Storage write request |
| st_ready | input | 1 | Storage sink accepts the write this cycle |
| st_addr | output | ST_AW (10) | Storage write address |
| st_data | output | 8 | Storage write byte |

## Verification
The assertions check the stream hold rule on every cycle. They also check that `st_valid` stays low while idle, that the storage pointer moves only on accepted writes, and the pointer results of pause and end. The order and content of the image are shown only by the bench scenarios: instruction, address bytes, register bytes, checksum values, address wrap, and resumption after a pause across two starts. The bench compares these byte by byte against a model of the script walk, with transfer lengths swept from one to 128 bytes under both steady and irregular ready patterns.

// File: rtl/cfg_upload_pkg.sv
package cfg_upload_pkg;
  localparam int RA_W = 16;
  localparam logic [7:0] OP_PAUSE = 8'hFE;
  localparam logic [7:0] OP_END   = 8'hFF;

  typedef enum logic [2:0] {
    UP_IDLE,
    UP_OP,
    UP_ADHI,
    UP_ADLO,
    UP_DATA,
    UP_SUM
  } up_state_e;
endpackage

// File: rtl/cfg_upload_decode.sv
module cfg_upload_decode
  import cfg_upload_pkg::*;
(
  input  logic [7:0] op,
  output logic       is_data,
  output logic       is_pause,
  output logic       is_end,
  output logic [6:0] span
);
  // Data codes occupy the lower half; span is the byte count minus one.
  assign is_data  = ~op[7];
  assign is_pause = (op == OP_PAUSE);
  assign is_end   = (op == OP_END);
  assign span     = op[6:0];
endmodule

// File: rtl/cfg_upload_csum.sv
module cfg_upload_csum (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       add,
  input  logic [7:0] byte_in,
  output logic [7:0] sum
);
  always_ff @(posedge clk) begin
    if (!rst_n)    sum <= 8'h00;
    else if (load) sum <= byte_in;
    else if (add)  sum <= sum + byte_in;
  end
endmodule

// File: rtl/cfg_upload_ptr.sv
module cfg_upload_ptr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         clr,
  output logic [W-1:0] val
);
  always_ff @(posedge clk) begin
    if (!rst_n)   val <= '0;
    else if (clr) val <= '0;
    else if (adv) val <= val + 1'b1;
  end
endmodule

// File: rtl/cfg_upload_seq.sv
module cfg_upload_seq
  import cfg_upload_pkg::*;
#(
  parameter logic [15:0] SP_BASE = 16'h0E00,
  parameter int          SP_AW   = 5,
  parameter int          ST_AW   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [RA_W-1:0]  rd_addr,
  input  logic [7:0]       rd_data,
  output logic             st_valid,
  input  logic             st_ready,
  output logic [ST_AW-1:0] st_addr,
  output logic [7:0]       st_data
);
  up_state_e state_q, state_d;

  logic [SP_AW-1:0] sp_ptr;
  logic [RA_W-1:0]  base_q;
  logic [6:0]       span_q, idx_q;
  logic [7:0]       sum;
  logic             is_data, is_pause, is_end;
  logic [6:0]       span;
  logic             hs, in_sp, sp_adv, ptr_clr, sum_load, sum_add;

  cfg_upload_decode u_dec (
    .op(rd_data), .is_data(is_data), .is_pause(is_pause),
    .is_end(is_end), .span(span)
  );

  assign hs       = st_valid & st_ready;
  assign in_sp    = (state_q == UP_OP) || (state_q == UP_ADHI) || (state_q == UP_ADLO);
  assign sp_adv   = in_sp && (hs || (state_q == UP_OP && is_pause));
  assign ptr_clr  = (state_q == UP_OP) && hs && is_end;
  assign sum_load = (state_q == UP_OP) && hs;
  assign sum_add  = hs && ((state_q == UP_ADHI) || (state_q == UP_ADLO) || (state_q == UP_DATA));
  assign busy     = (state_q != UP_IDLE);

  cfg_upload_ptr #(.W(SP_AW)) u_sp_ptr (
    .clk(clk), .rst_n(rst_n), .adv(sp_adv), .clr(ptr_clr), .val(sp_ptr)
  );

  cfg_upload_ptr #(.W(ST_AW)) u_st_ptr (
    .clk(clk), .rst_n(rst_n), .adv(hs), .clr(ptr_clr), .val(st_addr)
  );

  cfg_upload_csum u_sum (
    .clk(clk), .rst_n(rst_n), .load(sum_load), .add(sum_add),
    .byte_in(rd_data), .sum(sum)
  );

  // Read address and storage request
  always_comb begin
    rd_addr  = SP_BASE + RA_W'(sp_ptr);
    st_valid = 1'b0;
    st_data  = rd_data;
    case (state_q)
      UP_OP:   st_valid = ~is_pause;
      UP_ADHI,
      UP_ADLO: st_valid = 1'b1;
      UP_DATA: begin
        rd_addr  = base_q + RA_W'(idx_q);
        st_valid = 1'b1;
      end
      UP_SUM: begin
        st_valid = 1'b1;
        st_data  = sum;
      end
      default: ;
    endcase
  end

  // Walk control
  always_comb begin
    state_d = state_q;
    case (state_q)
      UP_IDLE: if (start) state_d = UP_OP;
      UP_OP: begin
        if (is_pause)     state_d = UP_IDLE;
        else if (hs) begin
          if (is_end)       state_d = UP_IDLE;
          else if (is_data) state_d = UP_ADHI;
        end
      end
      UP_ADHI: if (hs) state_d = UP_ADLO;
      UP_ADLO: if (hs) state_d = UP_DATA;
      UP_DATA: if (hs && idx_q == span_q) state_d = UP_SUM;
      UP_SUM:  if (hs) state_d = UP_OP;
      default: state_d = UP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= UP_IDLE;
      base_q  <= '0;
      span_q  <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (hs && state_q == UP_OP)   span_q <= span;
      if (hs && state_q == UP_ADHI) base_q[15:8] <= rd_data;
      if (hs && state_q == UP_ADLO) begin
        base_q[7:0] <= rd_data;
        idx_q       <= '0;
      end
      if (hs && state_q == UP_DATA) idx_q <= idx_q + 7'd1;
    end
  end

  // R8: stalled request is held unchanged
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_addr) && $stable(st_data)));

  // R9: storage pointer moves only on a completed write
  assert_ptr_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_valid && st_ready) |=> $stable(st_addr));

  // R1: no requests while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !st_valid);

  // R6: pause leaves storage pointer and goes idle
  assert_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == UP_OP && is_pause) |=> (!busy && $stable(st_addr)));

  // R7: end write clears the storage pointer and goes idle
  assert_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == UP_OP && hs && is_end) |=> (!busy && st_addr == '0));
endmodule

// File: tb/cfg_upload_seq_test.sv
module cfg_upload_seq_test;
  localparam int          SP_AW = 5;
  localparam int          ST_AW = 10;
  localparam logic [15:0] SPB   = 16'h0E00;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             st_ready = 1'b1;
  logic             busy, st_valid;
  logic [15:0]      rd_addr;
  logic [7:0]       rd_data, st_data;
  logic [ST_AW-1:0] st_addr;

  logic [7:0] sp [0:31];

  function automatic logic [7:0] regf(input logic [15:0] a);
    return (a[7:0] * 8'd5) ^ (a[15:8] + 8'h3C);
  endfunction

  assign rd_data = (rd_addr[15:5] == SPB[15:5]) ? sp[rd_addr[4:0]] : regf(rd_addr);

  cfg_upload_seq #(.SP_BASE(SPB), .SP_AW(SP_AW), .ST_AW(ST_AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .rd_addr(rd_addr), .rd_data(rd_data), .st_valid(st_valid),
    .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data)
  );

  int checks = 0;
  int fails  = 0;

  // Ready generator
  logic       rdy_mode = 1'b0;
  logic [7:0] lf = 8'h5A;
  always @(negedge clk) begin
    lf       <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    st_ready <= rdy_mode ? lf[0] : 1'b1;
  end

  // Write log and hold monitor
  logic [ST_AW-1:0] lg_a [0:1023];
  logic [7:0]       lg_d [0:1023];
  int               lg_n = 0;
  int               hold_err = 0;
  logic             pv = 1'b0;
  logic [ST_AW-1:0] pa = '0;
  logic [7:0]       pd = '0;
  always @(posedge clk) begin
    if (st_valid && st_ready) begin
      if (lg_n < 1024) begin
        lg_a[lg_n] <= st_addr;
        lg_d[lg_n] <= st_data;
      end
      lg_n <= lg_n + 1;
    end
    if (rst_n && pv && !(st_valid && st_addr == pa && st_data == pd))
      hold_err <= hold_err + 1;
    pv <= rst_n && st_valid && !st_ready;
    pa <= st_addr;
    pd <= st_data;
  end

  // Model of the script walk
  logic [SP_AW-1:0] msp = '0;
  logic [ST_AW-1:0] mst = '0;
  logic [ST_AW-1:0] ex_a [0:255];
  logic [7:0]       ex_d [0:255];
  string            ex_r [0:255];
  int               ex_n;

  task automatic push(input logic [7:0] d, input string r);
    ex_a[ex_n] = mst;
    ex_d[ex_n] = d;
    ex_r[ex_n] = r;
    ex_n++;
    mst++;
  endtask

  function automatic logic [7:0] mrd(input logic [15:0] a);
    return (a[15:5] == SPB[15:5]) ? sp[a[4:0]] : regf(a);
  endfunction

  task automatic model_run();
    logic [7:0] op, hi, lo, cs;
    logic [15:0] a;
    ex_n = 0;
    for (int k = 0; k < 64; k++) begin
      op = sp[msp];
      msp++;
      if (op == 8'hFE) break;
      if (op == 8'hFF) begin
        push(op, "R7");
        msp = '0;
        mst = '0;
        break;
      end
      if (op[7]) begin
        push(op, "R5");
      end else begin
        push(op, "R2");
        hi = sp[msp]; msp++;
        lo = sp[msp]; msp++;
        push(hi, "R3");
        push(lo, "R3");
        cs = op + hi + lo;
        a = {hi, lo};
        for (int i = 0; i <= int'(op); i++) begin
          push(mrd(a + 16'(i)), "R2");
          cs = cs + mrd(a + 16'(i));
        end
        push(cs, "R4");
      end
    end
  endtask

  task automatic check(input bit ok, input string r, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic fill_sp();
    for (int i = 0; i < 32; i++) sp[i] = 8'hFF;
  endtask

  int last_base;

  task automatic run_and_check(input string name);
    int base, got, waited;
    base = lg_n;
    last_base = base;
    model_run();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy === 1'b1, "R1", {name, " busy after start"}, int'(busy), 1);
    repeat (2) @(negedge clk);
    if (busy) begin
      start = 1'b1;  // R1: must be ignored while busy
      @(negedge clk) start = 1'b0;
    end
    waited = 0;
    while (busy && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    check(!busy, "R1", {name, " walk finished"}, int'(busy), 0);
    repeat (2) @(negedge clk);
    got = lg_n - base;
    check(got == ex_n, "R2", {name, " write count"}, got, ex_n);
    for (int i = 0; i < ex_n && i < got; i++) begin
      check(lg_d[base + i] == ex_d[i], ex_r[i], {name, " data"}, lg_d[base + i], ex_d[i]);
      check(lg_a[base + i] == ex_a[i], "R9", {name, " address"}, lg_a[base + i], ex_a[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    fill_sp();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R1", "reset busy", int'(busy), 0);
    check(st_valid === 1'b0, "R1", "reset st_valid", int'(st_valid), 0);

    // Mixed script: data, single-byte codes, data, end
    sp[0] = 8'h02; sp[1] = 8'h12; sp[2] = 8'h34;
    sp[3] = 8'h80; sp[4] = 8'hB5;
    sp[5] = 8'h00; sp[6] = 8'h00; sp[7] = 8'h7F;
    sp[8] = 8'hA1; sp[9] = 8'hFF;
    run_and_check("mixed");
    // R7: after end, replay starts at script 0 and storage 0
    rdy_mode = 1'b1;
    run_and_check("replay");
    check(lg_a[last_base] == '0, "R7", "restart storage address", lg_a[last_base], 0);
    check(lg_d[last_base] == 8'h02, "R7", "restart first byte", lg_d[last_base], 2);

    // Pause splits two sequences
    fill_sp();
    sp[0] = 8'hA0; sp[1] = 8'h01; sp[2] = 8'hAB; sp[3] = 8'hCD; sp[4] = 8'hFE;
    sp[5] = 8'hCF; sp[6] = 8'h00; sp[7] = 8'h00; sp[8] = 8'h10; sp[9] = 8'hFF;
    run_and_check("before pause");
    check(lg_n - last_base == 7, "R6", "pause writes nothing", lg_n - last_base, 7);
    run_and_check("after pause");
    check(lg_a[last_base] == 10'd7, "R6", "resume storage address",
          lg_a[last_base], 7);
    check(lg_d[last_base] == 8'hCF, "R6", "resume script position",
          lg_d[last_base], 8'hCF);

    // Length sweep, both ready patterns, including address wrap
    for (int j = 0; j < 8; j++) begin
      logic [7:0]  n;
      logic [15:0] a;
      case (j)
        0: n = 8'd0;   1: n = 8'd1;   2: n = 8'd2;   3: n = 8'd5;
        4: n = 8'd16;  5: n = 8'd63;  6: n = 8'd100; default: n = 8'd127;
      endcase
      a = (j == 3) ? 16'hFFFD : 16'h1000 + 16'(j * 37);
      fill_sp();
      sp[0] = n; sp[1] = a[15:8]; sp[2] = a[7:0]; sp[3] = 8'hFF;
      rdy_mode = j[0];
      run_and_check("sweep");
    end

    check(hold_err == 0, "R8", "stalled request held", hold_err, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule